// File: doc/BRIEF.md
# Cached Hash-Tree Memory Integrity Checker

This block confirms that a word fetched from untrusted external memory is the most recent value the processor stored at that location. The protected region holds `2**DEPTH` data words. These words form the leaves of a binary hash tree, and the tree's internal nodes are also kept in the untrusted memory. The only value the block must hold in trusted storage is the root hash, one `W`-bit register (128 bits by default). A per-address keyed tag would not be enough, because an attacker can replay an old value together with its old tag. The chain of hashes up to a trusted node is what defeats replay.

For a read, the block fetches the leaf word and hands it to the requester at once, before the check is done. It then fetches sibling hashes one level at a time and recomputes each ancestor. The climb ends at the root, or earlier at the first ancestor found in a small direct-mapped on-chip cache of trusted node hashes. If a recomputed hash differs from the trusted one, the block pulses an abort and raises a sticky failure flag. For a write, the block stores the leaf and then recomputes every ancestor. It writes each non-root ancestor back to memory, installs it in the cache, and finally replaces the root register.

The block accepts one request at a time. A new request waits until the result of the current one has been reported.

Top module: `hash_tree_verifier`

## Requirements
- R1: During and after reset, `req_ready` is 1 and `done_valid`, `abort`, `fail_flag` and `mem_req` are 0. The cache holds no entries. The root register holds the root of a tree whose leaves are all zero.
- R2: Nodes use heap numbering, and the memory address of a node equals its index. The root is index 1. Leaf `a` is index `2**DEPTH + a`. The parent of node i is i>>1, and its sibling is i^1. Each parent equals H(left, right), where the left child has the even index. H(l, r) = (rotl(l,7) + r) ^ rotl(r,29) ^ K, with K the byte A5 repeated across W bits. Address 0 is never accessed.
- R3: A write stores the data at the leaf and writes each recomputed non-root ancestor to its own address. It updates the root register. It reports `done_valid` with `done_ok`=1 in the cycle that follows the 3*DEPTH-th rising edge after the accepting edge.
- R4: A read raises `rsp_valid` for one cycle, one edge after acceptance, with `rsp_data` equal to the leaf word fetched from memory. This happens before the check completes, and `rsp_valid` is never high together with `done_valid`.
- R5: A read with no cache hit on its path fetches DEPTH siblings. It reports in the cycle after edge 3+2*DEPTH, and the result is good only if the recomputed root equals the root register.
- R6: A read stops at the first internal ancestor whose hash is in the cache, and compares against that entry. After m sibling fetches it reports in the cycle after edge 3+2*m. Memory nodes above the stopping point are never read, so altering them has no effect on the result.
- R7: The cache is direct-mapped with CACHE_N slots, and node i lives in slot i mod CACHE_N. Each write installs every non-root ancestor on its path, from the bottom up, and replaces any previous occupant of that slot. The root and the leaves are never cached.
- R8: On a mismatch, `abort` pulses together with `done_valid` and `done_ok`=0. A replayed old leaf value is caught in this way.
- R9: `fail_flag` rises with the first abort and stays high until reset, even after later good results.
- R10: `req_ready` is low from the accepting edge until the cycle in which that request's result is reported. A request held during this time is accepted only then.
- R11: Each accepted request produces exactly one single-cycle `done_valid`, and results come out in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | DEPTH | Leaf (word) number |
| req_wdata | input | W | Write data |
| rsp_valid | output | 1 | Speculative read data strobe |
| rsp_data | output | W | Speculative read data |
| done_valid | output | 1 | Result strobe |
| done_ok | output | 1 | Result good |
| abort | output | 1 | Integrity mismatch on this request |
| fail_flag | output | 1 | Sticky integrity failure |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | DEPTH+1 | Node index |
| mem_wdata | output | W | Node value to store |
| mem_rdata | input | W | Node value returned, held until the next read |

## Verification
Every result has a fixed due cycle, counted from the accepting edge. Speculative data is due after one edge. A read result is due after 3+2*m edges, where m is the number of sibling fetches a model of the cache and tree predicts. A write result is due after 3*DEPTH edges. The monitor records the cycle in which it sees a request accepted, and compares the result strobe's arrival against that cycle plus the predicted latency. Each expected item carries its own latency, so a result that arrives early or late counts as a mismatch, even when its pass/fail value is right.

// File: rtl/hash_tree_verifier.sv
module hash_tree_verifier #(
  parameter int DEPTH   = 3,
  parameter int W       = 128,
  parameter int CACHE_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [DEPTH-1:0] req_addr,
  input  logic [W-1:0]     req_wdata,
  output logic             rsp_valid,
  output logic [W-1:0]     rsp_data,
  output logic             done_valid,
  output logic             done_ok,
  output logic             abort,
  output logic             fail_flag,
  output logic             mem_req,
  output logic             mem_we,
  output logic [DEPTH:0]   mem_addr,
  output logic [W-1:0]     mem_wdata,
  input  logic [W-1:0]     mem_rdata
);
  localparam int LEAVES = 1 << DEPTH;
  localparam int IW = DEPTH + 1;
  localparam int CW = $clog2(CACHE_N);
  localparam logic [W-1:0] KEY = {(W/8){8'hA5}};

  typedef enum logic [2:0] {
    S_IDLE, S_RLEAF, S_RDATA, S_CHK, S_SIB, S_WPUT, S_WREQ, S_WSIB
  } st_t;

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int n);
    return (x << n) | (x >> (W - n));
  endfunction

  function automatic logic [W-1:0] hfn(input logic [W-1:0] l, input logic [W-1:0] r);
    return (rotl(l, 7) + r) ^ rotl(r, 29) ^ KEY;
  endfunction

  function automatic logic [W-1:0] zero_root();
    logic [W-1:0] z;
    z = '0;
    for (int k = 0; k < DEPTH; k++) z = hfn(z, z);
    return z;
  endfunction

  st_t             st;
  logic [IW-1:0]   idx;
  logic [W-1:0]    cur;
  logic [W-1:0]    root;
  logic            cv   [CACHE_N];
  logic [IW-1:0]   ctag [CACHE_N];
  logic [W-1:0]    ch   [CACHE_N];

  logic [CW-1:0]   slot, pslot;
  logic [IW-1:0]   par;
  logic            at_root, hit, stop, match;
  logic [W-1:0]    trusted, parent_h;

  assign slot     = idx[CW-1:0];
  assign par      = {1'b0, idx[IW-1:1]};
  assign pslot    = par[CW-1:0];
  assign at_root  = (idx == IW'(1));
  assign hit      = (idx < IW'(LEAVES)) && cv[slot] && (ctag[slot] == idx);
  assign stop     = at_root || hit;
  assign trusted  = at_root ? root : ch[slot];
  assign match    = (cur == trusted);
  assign parent_h = idx[0] ? hfn(mem_rdata, cur) : hfn(cur, mem_rdata);

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RDATA);
  assign rsp_data  = mem_rdata;
  assign mem_req   = (st == S_RLEAF) || (st == S_WPUT) || (st == S_WREQ) ||
                     ((st == S_CHK) && !stop);
  assign mem_we    = (st == S_WPUT);
  assign mem_addr  = ((st == S_RLEAF) || (st == S_WPUT)) ? idx : (idx ^ IW'(1));
  assign mem_wdata = cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      idx        <= '0;
      cur        <= '0;
      root       <= zero_root();
      done_valid <= 1'b0;
      done_ok    <= 1'b0;
      abort      <= 1'b0;
      fail_flag  <= 1'b0;
      for (int i = 0; i < CACHE_N; i++) begin
        cv[i]   <= 1'b0;
        ctag[i] <= '0;
        ch[i]   <= '0;
      end
    end else begin
      done_valid <= 1'b0;
      abort      <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          idx <= {1'b1, req_addr};
          cur <= req_wdata;
          st  <= req_write ? S_WPUT : S_RLEAF;
        end
        S_RLEAF: st <= S_RDATA;
        S_RDATA: begin
          cur <= mem_rdata;
          st  <= S_CHK;
        end
        S_CHK: if (stop) begin
          done_valid <= 1'b1;
          done_ok    <= match;
          abort      <= !match;
          fail_flag  <= fail_flag | !match;
          st         <= S_IDLE;
        end else begin
          st <= S_SIB;
        end
        S_SIB: begin
          cur <= parent_h;
          idx <= par;
          st  <= S_CHK;
        end
        S_WPUT: st <= S_WREQ;
        S_WREQ: st <= S_WSIB;
        S_WSIB: begin
          cur <= parent_h;
          idx <= par;
          if (par == IW'(1)) begin
            root       <= parent_h;
            done_valid <= 1'b1;
            done_ok    <= 1'b1;
            st         <= S_IDLE;
          end else begin
            cv[pslot]   <= 1'b1;
            ctag[pslot] <= par;
            ch[pslot]   <= parent_h;
            st          <= S_WPUT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R11
  AST_ABORT_IS_BAD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (done_valid && !done_ok)); // R8
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag |=> fail_flag); // R9
  AST_ABORT_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> fail_flag); // R9
  AST_STALL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R10
  AST_SPEC_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !done_valid); // R4
  AST_NO_NODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr != '0)); // R2
endmodule

// File: tb/hash_tree_verifier_tb_top.sv
module hash_tree_verifier_tb_top;
  localparam int DEPTH = 3;
  localparam int W = 128;
  localparam int CN = 4;
  localparam int LEAVES = 1 << DEPTH;
  localparam int NODES = 2 * LEAVES;
  localparam logic [W-1:0] KEY = {(W/8){8'hA5}};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [DEPTH-1:0] req_addr = '0;
  logic [W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, done_valid, done_ok, abort, fail_flag;
  logic [W-1:0] rsp_data;
  logic mem_req, mem_we;
  logic [DEPTH:0] mem_addr;
  logic [W-1:0] mem_wdata;
  logic [W-1:0] mem_rdata = '0;

  hash_tree_verifier #(.DEPTH(DEPTH), .W(W), .CACHE_N(CN)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done_valid(done_valid),
    .done_ok(done_ok), .abort(abort), .fail_flag(fail_flag),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  logic [W-1:0] mem [NODES];

  always @(negedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] = mem_wdata;
      else        mem_rdata = mem[mem_addr];
    end
  end

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int n);
    return (x << n) | (x >> (W - n));
  endfunction
  function automatic logic [W-1:0] hfn(input logic [W-1:0] l, input logic [W-1:0] r);
    return (rotl(l, 7) + r) ^ rotl(r, 29) ^ KEY;
  endfunction

  typedef struct {
    bit wr;
    bit ok;
    int lat;
    logic [W-1:0] data;
    string tag;
  } exp_t;
  exp_t q[$];

  int compared = 0, mismatched = 0, cyc = 0, t0 = 0;
  logic [W-1:0] mroot;
  bit mcv [CN];
  int mctag [CN];
  logic [W-1:0] mch [CN];

  task automatic check(input bit cond, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] expv);
    compared++;
    if (!cond) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (done_valid) begin
        if (q.size() == 0) check(1'b0, "R11", "unexpected result", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(done_ok == e.ok, e.tag, "done_ok", done_ok, e.ok);
          check(abort == !e.ok, "R8", "abort", abort, !e.ok);
          check(cyc - t0 == e.lat + 1, e.tag, "latency", cyc - t0, e.lat + 1);
        end
      end
      if (req_valid && req_ready) t0 = cyc;
      if (q.size() > 0 && !q[0].wr && cyc == t0 + 2)
        check(rsp_valid && rsp_data == q[0].data, "R4", "speculative data",
              rsp_data, q[0].data);
    end
  end

  task automatic send(input int a, input bit w, input logic [W-1:0] d, output bit stalled);
    @(posedge clk); #2;
    req_valid = 1'b1; req_write = w; req_addr = DEPTH'(a); req_wdata = d;
    stalled = 1'b0;
    forever begin
      @(negedge clk);
      if (req_ready) break;
      stalled = 1'b1;
    end
    if (stalled) check(done_valid == 1'b1, "R10", "accept only with prior result", done_valid, 1);
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do begin @(negedge clk); #1; end while (q.size() != 0);
  endtask

  task automatic do_read(input int a, input string tag, input bit stall_expected);
    exp_t e;
    int idx, m;
    logic [W-1:0] h;
    bit fin, st;
    idx = LEAVES + a; h = mem[idx]; m = 0; fin = 0;
    e.ok = 0;
    for (int lv = 0; lv <= DEPTH; lv++) begin
      if (!fin) begin
        if (idx == 1) begin e.ok = (h == mroot); fin = 1; end
        else if (idx < LEAVES && mcv[idx % CN] && mctag[idx % CN] == idx) begin
          e.ok = (h == mch[idx % CN]); fin = 1;
        end else begin
          h = (idx % 2 == 1) ? hfn(mem[idx ^ 1], h) : hfn(h, mem[idx ^ 1]);
          idx = idx / 2; m++;
        end
      end
    end
    e.wr = 0; e.lat = 3 + 2 * m; e.data = mem[LEAVES + a]; e.tag = tag;
    q.push_back(e);
    send(a, 1'b0, '0, st);
    if (stall_expected) check(st, "R10", "second request held off", st, 1);
  endtask

  task automatic do_write(input int a, input logic [W-1:0] d);
    exp_t e;
    int idx, pidx [DEPTH];
    logic [W-1:0] h, pval [DEPTH];
    bit st;
    idx = LEAVES + a; h = d;
    for (int lv = 0; lv < DEPTH; lv++) begin
      h = (idx % 2 == 1) ? hfn(mem[idx ^ 1], h) : hfn(h, mem[idx ^ 1]);
      idx = idx / 2;
      pidx[lv] = idx; pval[lv] = h;
    end
    e.wr = 1; e.ok = 1; e.lat = 3 * DEPTH; e.data = '0; e.tag = "R3";
    q.push_back(e);
    send(a, 1'b1, d, st);
    wait_idle();
    check(mem[LEAVES + a] == d, "R3", "leaf stored", mem[LEAVES + a], d);
    for (int lv = 0; lv < DEPTH - 1; lv++) begin
      check(mem[pidx[lv]] == pval[lv], "R2", "ancestor hash in memory", mem[pidx[lv]], pval[lv]);
      mcv[pidx[lv] % CN] = 1; mctag[pidx[lv] % CN] = pidx[lv]; mch[pidx[lv] % CN] = pval[lv];
    end
    mroot = pval[DEPTH - 1];
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0;
    for (int i = NODES - 1; i >= 1; i--)
      mem[i] = (i >= LEAVES) ? '0 : hfn(mem[2 * i], mem[2 * i + 1]);
    mem[0] = '0;
    mroot = mem[1];
    for (int i = 0; i < CN; i++) begin mcv[i] = 0; mctag[i] = 0; mch[i] = '0; end
    repeat (3) @(posedge clk);
    #2;
    check(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
    check(!done_valid && !abort && !mem_req, "R1", "strobes idle in reset",
          {done_valid, abort, mem_req}, 0);
    check(fail_flag == 1'b0, "R1", "fail_flag cleared", fail_flag, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R11", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [W-1:0] saved, old_leaf;
    do_reset();
    do_read(3, "R5", 0); wait_idle();
    do_write(0, 128'h0123_4567_89AB_CDEF_1111_2222_3333_4444);
    do_read(0, "R6", 0); wait_idle();
    do_read(1, "R6", 0); wait_idle();
    do_read(3, "R6", 0); wait_idle();

    saved = mem[3]; mem[3] = mem[3] ^ 128'h1;
    do_read(0, "R6", 0); wait_idle();
    check(fail_flag == 1'b0, "R6", "bypassed tamper has no effect", fail_flag, 0);
    mem[3] = saved;

    do_read(6, "R5", 0);
    do_read(7, "R10", 1); wait_idle();

    do_write(4, 128'hDEAD_BEEF_0000_0000_0000_0000_CAFE_F00D);
    do_read(3, "R7", 0); wait_idle();

    do_write(5, 128'h5555_0000_0000_0000_0000_0000_0000_0001);
    old_leaf = mem[LEAVES + 5];
    do_write(5, 128'h5555_0000_0000_0000_0000_0000_0000_0002);
    saved = mem[LEAVES + 5];
    mem[LEAVES + 5] = old_leaf;
    do_read(5, "R8", 0); wait_idle();
    check(fail_flag == 1'b1, "R9", "flag after abort", fail_flag, 1);
    mem[LEAVES + 5] = saved;
    do_read(5, "R6", 0); wait_idle();
    check(fail_flag == 1'b1, "R9", "flag holds after good read", fail_flag, 1);

    do_reset();
    mem[LEAVES + 3] = mem[LEAVES + 3] ^ 128'h80;
    do_read(3, "R8", 0); wait_idle();
    check(fail_flag == 1'b1, "R9", "flag after root mismatch", fail_flag, 1);

    repeat (3) @(posedge clk);
    check(q.size() == 0, "R11", "all results returned", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule